// File: doc/BRIEF.md
# Channel Stream Hub

This block sits between a packet engine and a set of user modules. The engine drives one shared pair of byte streams, one toward the users (downstream) and one back from them (upstream), plus a channel address. The hub turns that address into one enable per channel. It steers the downstream stream to the addressed channel and takes the upstream stream from that same channel. Each user module therefore sees an enable and a private stream in each direction. The hub stores no data, so every byte passes through in the cycle it is offered.

Both streams use valid/ready handshaking, and a byte moves only in a cycle where both are high. Either side may apply back-pressure at any time. A producer that lowers valid mid-frame simply pauses the frame, and a consumer that lowers ready holds the current byte in place. Every beat also carries a frame-start flag and a frame-end flag. The selected channel is captured when a frame opens and stays fixed until that frame closes, so a change of address in the middle of a frame cannot split it across channels.

Top module: `chan_stream_hub`

## Requirements
- R1: `ch_en` is one-hot or zero. Address value a, with 1 ≤ a ≤ NUM_CH, raises bit a-1 alone. Address 0, and any value above NUM_CH, raises no bit.
- R2: `dn_valid[i]` equals `ch_en[i]` AND `eng_dn_valid`. The engine's data byte, frame-start flag and frame-end flag are copied to every channel's downstream data, `dn_sof` and `dn_eof` in the same cycle.
- R3: `eng_dn_ready` equals `dn_ready[i]` of the enabled channel, and is 0 when no channel is enabled.
- R4: `eng_up_valid`, `eng_up_data`, `eng_up_sof` and `eng_up_eof` are the enabled channel's upstream valid, byte (bits [8i+7:8i] of `up_data` for channel i), frame-start and frame-end. All of them are 0 when no channel is enabled.
- R5: `up_ready[i]` equals `ch_en[i]` AND `eng_up_ready`, so a channel that is not enabled never sees ready.
- R6: The hub adds no latency and holds no bytes. When a producer lowers valid mid-frame, the consumer's valid drops in the same cycle, and the next byte arrives unchanged when valid returns.
- R7: An accepted beat (valid and ready both high) that has frame-start set and frame-end clear, in either direction, opens a frame. While any frame is open, `ch_en` keeps the value it had on that opening beat, whatever the address does. A frame-start beat that is not accepted opens nothing.
- R8: An accepted beat that has frame-end set closes that direction's frame. Once no frame is open, `ch_en` follows the live address from the next cycle on. This includes a one-beat frame, which has both flags set.
- R9: After reset no frame is open, and `ch_en` follows the live address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_addr | input | ADDR_W | Channel address from the engine |
| eng_dn_valid | input | 1 | Engine downstream byte valid |
| eng_dn_ready | output | 1 | Selected channel can accept the downstream byte |
| eng_dn_data | input | DATA_W | Engine downstream byte |
| eng_dn_sof | input | 1 | Downstream frame-start flag |
| eng_dn_eof | input | 1 | Downstream frame-end flag |
| eng_up_valid | output | 1 | Upstream byte valid from the selected channel |
| eng_up_ready | input | 1 | Engine can accept an upstream byte |
| eng_up_data | output | DATA_W | Upstream byte from the selected channel |
| eng_up_sof | output | 1 | Upstream frame-start flag |
| eng_up_eof | output | 1 | Upstream frame-end flag |
| ch_en | output | NUM_CH | Per-channel enable |
| dn_valid | output | NUM_CH | Per-channel downstream valid |
| dn_ready | input | NUM_CH | Per-channel downstream ready |
| dn_data | output | NUM_CH*DATA_W | Per-channel downstream bytes, channel i at [8i+7:8i] |
| dn_sof | output | NUM_CH | Per-channel downstream frame-start flag |
| dn_eof | output | NUM_CH | Per-channel downstream frame-end flag |
| up_valid | input | NUM_CH | Per-channel upstream valid |
| up_ready | output | NUM_CH | Per-channel upstream ready |
| up_data | input | NUM_CH*DATA_W | Per-channel upstream bytes, channel i at [8i+7:8i] |
| up_sof | input | NUM_CH | Per-channel upstream frame-start flag |
| up_eof | input | NUM_CH | Per-channel upstream frame-end flag |

## Verification
The only state in the hub is the two frame-open flags and the captured selection. If a flag sticks, the enable ignores address changes from then on. The first cycle in which the address moves while the link is idle shows the fault. If a flag is lost, the enable follows an address change in the middle of a frame, so bytes reach the wrong channel on that very beat. A bad captured value appears on the cycle after an opening beat, as a wrong `ch_en` and a byte steered to the wrong channel. The routing paths are combinational, so any fault in them is visible at the ports in the same cycle as the stimulus that exercises it.

// File: rtl/sfo_pkg.sv
package sfo_pkg;
  // Hardware ceiling on channels and the address width that reaches it
  localparam int unsigned CH_LIMIT  = 15;
  localparam int unsigned ADDR_BITS = 4;

  // Next state of a frame-open flag given one beat of the stream
  function automatic logic frame_next(input logic open, input logic beat,
                                      input logic sof, input logic eof);
    if (!beat) return open;
    if (eof)   return 1'b0;
    if (sof)   return 1'b1;
    return open;
  endfunction
endpackage

// File: rtl/sfo_chan_select.sv
module sfo_chan_select
  import sfo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = ADDR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dn_beat,
  input  logic              dn_sof,
  input  logic              dn_eof,
  input  logic              up_beat,
  input  logic              up_sof,
  input  logic              up_eof,
  output logic [NUM_CH-1:0] en
);
  logic [NUM_CH-1:0] live;
  logic [NUM_CH-1:0] sel_q;
  logic              dn_open_q, up_open_q;
  logic              hold, start;

  // Live address decode: value i+1 selects channel i
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign live[i] = (addr == ADDR_W'(i + 1));
  end

  assign hold  = dn_open_q | up_open_q;
  assign en    = hold ? sel_q : live;
  assign start = (dn_beat & dn_sof & ~dn_eof) | (up_beat & up_sof & ~up_eof);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_open_q <= 1'b0;
      up_open_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      dn_open_q <= frame_next(dn_open_q, dn_beat, dn_sof, dn_eof);
      up_open_q <= frame_next(up_open_q, up_beat, up_sof, up_eof);
      if (start && !hold) sel_q <= live;
    end
  end

  // R7: an opening downstream beat freezes the enable for the next cycle
  a_r7_open_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_beat & dn_sof & ~dn_eof) |=> $stable(en));

  // R1: idle link with an out-of-range address enables nothing
  a_r1_range_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (addr == '0 || int'(addr) > NUM_CH)) |-> (en == '0));
endmodule

// File: rtl/sfo_down_fanout.sv
module sfo_down_fanout #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic [NUM_CH-1:0]        en,
  input  logic                     src_valid,
  input  logic [DATA_W-1:0]        src_data,
  input  logic                     src_sof,
  input  logic                     src_eof,
  output logic                     src_ready,
  output logic [NUM_CH-1:0]        ch_valid,
  input  logic [NUM_CH-1:0]        ch_ready,
  output logic [NUM_CH*DATA_W-1:0] ch_data,
  output logic [NUM_CH-1:0]        ch_sof,
  output logic [NUM_CH-1:0]        ch_eof
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_valid[i]                  = en[i] & src_valid;
    assign ch_data[i*DATA_W +: DATA_W]  = src_data;
    assign ch_sof[i]                    = src_sof;
    assign ch_eof[i]                    = src_eof;
  end

  assign src_ready = |(en & ch_ready);
endmodule

// File: rtl/sfo_up_merge.sv
module sfo_up_merge #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic [NUM_CH-1:0]        en,
  input  logic [NUM_CH-1:0]        ch_valid,
  output logic [NUM_CH-1:0]        ch_ready,
  input  logic [NUM_CH*DATA_W-1:0] ch_data,
  input  logic [NUM_CH-1:0]        ch_sof,
  input  logic [NUM_CH-1:0]        ch_eof,
  output logic                     dst_valid,
  input  logic                     dst_ready,
  output logic [DATA_W-1:0]        dst_data,
  output logic                     dst_sof,
  output logic                     dst_eof
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_rdy
    assign ch_ready[i] = en[i] & dst_ready;
  end

  // AND-OR select: the enable is one-hot or zero, so no priority is needed
  always_comb begin
    dst_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      dst_data = dst_data | (ch_data[i*DATA_W +: DATA_W] & {DATA_W{en[i]}});
    end
  end

  assign dst_valid = |(en & ch_valid);
  assign dst_sof   = |(en & ch_sof);
  assign dst_eof   = |(en & ch_eof);
endmodule

// File: rtl/chan_stream_hub.sv
module chan_stream_hub
  import sfo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = ADDR_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        eng_addr,
  input  logic                     eng_dn_valid,
  output logic                     eng_dn_ready,
  input  logic [DATA_W-1:0]        eng_dn_data,
  input  logic                     eng_dn_sof,
  input  logic                     eng_dn_eof,
  output logic                     eng_up_valid,
  input  logic                     eng_up_ready,
  output logic [DATA_W-1:0]        eng_up_data,
  output logic                     eng_up_sof,
  output logic                     eng_up_eof,
  output logic [NUM_CH-1:0]        ch_en,
  output logic [NUM_CH-1:0]        dn_valid,
  input  logic [NUM_CH-1:0]        dn_ready,
  output logic [NUM_CH*DATA_W-1:0] dn_data,
  output logic [NUM_CH-1:0]        dn_sof,
  output logic [NUM_CH-1:0]        dn_eof,
  input  logic [NUM_CH-1:0]        up_valid,
  output logic [NUM_CH-1:0]        up_ready,
  input  logic [NUM_CH*DATA_W-1:0] up_data,
  input  logic [NUM_CH-1:0]        up_sof,
  input  logic [NUM_CH-1:0]        up_eof
);
  logic dn_beat, up_beat;

  assign dn_beat = eng_dn_valid & eng_dn_ready;
  assign up_beat = eng_up_valid & eng_up_ready;

  sfo_chan_select #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (eng_addr),
    .dn_beat (dn_beat),
    .dn_sof  (eng_dn_sof),
    .dn_eof  (eng_dn_eof),
    .up_beat (up_beat),
    .up_sof  (eng_up_sof),
    .up_eof  (eng_up_eof),
    .en      (ch_en)
  );

  sfo_down_fanout #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dn (
    .en        (ch_en),
    .src_valid (eng_dn_valid),
    .src_data  (eng_dn_data),
    .src_sof   (eng_dn_sof),
    .src_eof   (eng_dn_eof),
    .src_ready (eng_dn_ready),
    .ch_valid  (dn_valid),
    .ch_ready  (dn_ready),
    .ch_data   (dn_data),
    .ch_sof    (dn_sof),
    .ch_eof    (dn_eof)
  );

  sfo_up_merge #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_up (
    .en        (ch_en),
    .ch_valid  (up_valid),
    .ch_ready  (up_ready),
    .ch_data   (up_data),
    .ch_sof    (up_sof),
    .ch_eof    (up_eof),
    .dst_valid (eng_up_valid),
    .dst_ready (eng_up_ready),
    .dst_data  (eng_up_data),
    .dst_sof   (eng_up_sof),
    .dst_eof   (eng_up_eof)
  );

  // R1: never more than one channel enabled
  a_r1_en_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_en));

  // R2: at most one channel sees a downstream byte, and only when offered
  a_r2_dn_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid) && (!(|dn_valid) || eng_dn_valid));

  // R3: ready toward the engine implies a selected channel
  a_r3_ready_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    eng_dn_ready |-> (ch_en != '0));

  // R4: upstream valid implies a selected channel
  a_r4_valid_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    eng_up_valid |-> (ch_en != '0));

  // R5: a channel is given ready only when the engine is ready
  a_r5_up_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (|up_ready) |-> (eng_up_ready && $onehot(up_ready)));
endmodule

// File: tb/chan_stream_hub_bench.sv
module chan_stream_hub_bench;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     eng_addr = '0;
  logic              eng_dn_valid = 1'b0;
  logic              eng_dn_ready;
  logic [DW-1:0]     eng_dn_data = '0;
  logic              eng_dn_sof = 1'b0;
  logic              eng_dn_eof = 1'b0;
  logic              eng_up_valid;
  logic              eng_up_ready = 1'b0;
  logic [DW-1:0]     eng_up_data;
  logic              eng_up_sof;
  logic              eng_up_eof;
  logic [N-1:0]      ch_en;
  logic [N-1:0]      dn_valid;
  logic [N-1:0]      dn_ready = '0;
  logic [N*DW-1:0]   dn_data;
  logic [N-1:0]      dn_sof;
  logic [N-1:0]      dn_eof;
  logic [N-1:0]      up_valid = '0;
  logic [N-1:0]      up_ready;
  logic [N*DW-1:0]   up_data = '0;
  logic [N-1:0]      up_sof = '0;
  logic [N-1:0]      up_eof = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  chan_stream_hub #(.NUM_CH(N), .DATA_W(DW), .ADDR_W(AW)) u_chan_stream_hub (
    .clk(clk), .rst_n(rst_n), .eng_addr(eng_addr),
    .eng_dn_valid(eng_dn_valid), .eng_dn_ready(eng_dn_ready),
    .eng_dn_data(eng_dn_data), .eng_dn_sof(eng_dn_sof), .eng_dn_eof(eng_dn_eof),
    .eng_up_valid(eng_up_valid), .eng_up_ready(eng_up_ready),
    .eng_up_data(eng_up_data), .eng_up_sof(eng_up_sof), .eng_up_eof(eng_up_eof),
    .ch_en(ch_en), .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .dn_sof(dn_sof), .dn_eof(dn_eof), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .up_sof(up_sof), .up_eof(up_eof)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_en(input int a);
    return (a >= 1 && a <= N) ? N'(1 << (a - 1)) : '0;
  endfunction

  function automatic logic [DW-1:0] sel_byte(input logic [N-1:0] en, input logic [N*DW-1:0] bus);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < N; i++) if (en[i]) r = bus[i*DW +: DW];
    return r;
  endfunction

  task automatic idle_inputs();
    eng_dn_valid = 1'b0; eng_dn_sof = 1'b0; eng_dn_eof = 1'b0;
    eng_up_ready = 1'b0; dn_ready = '0; up_valid = '0;
    up_sof = '0; up_eof = '0;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state with an out-of-range address
    #2;
    chk("R9 en after reset", 32'(ch_en), 32'(0));
    chk("R9 dn ready after reset", 32'(eng_dn_ready), 32'(0));
    chk("R9 up valid after reset", 32'(eng_up_valid), 32'(0));
    chk("R9 up ready after reset", 32'(up_ready), 32'(0));

    // Sweep: every address against every ready/valid pattern, no frames opened
    for (int a = 0; a < 16; a++) begin
      for (int p = 0; p < 256; p++) begin
        logic [N-1:0]    e;
        logic [7:0]      pb;
        logic [N*DW-1:0] ud;
        @(negedge clk);
        pb = 8'(p);
        eng_addr     = AW'(a);
        eng_dn_valid = pb[0];
        eng_up_ready = pb[1];
        dn_ready     = pb[4:2];
        up_valid     = pb[7:5];
        eng_dn_data  = pb ^ 8'(a);
        eng_dn_sof   = 1'b0;
        eng_dn_eof   = pb[1];
        for (int i = 0; i < N; i++) ud[i*DW +: DW] = 8'(16 * (i + 1)) ^ pb;
        up_data = ud;
        up_sof  = '0;
        up_eof  = {pb[5], pb[7], pb[6]};
        #2;
        e = exp_en(a);
        chk("R1 decode", 32'(ch_en), 32'(e));
        chk("R2 dn valid", 32'(dn_valid), 32'(e & {N{pb[0]}}));
        for (int i = 0; i < N; i++) begin
          chk("R2 dn data copy", 32'(dn_data[i*DW +: DW]), 32'(pb ^ 8'(a)));
          chk("R2 dn eof copy", 32'(dn_eof[i]), 32'(pb[1]));
        end
        chk("R3 dn ready", 32'(eng_dn_ready), 32'(|(e & pb[4:2])));
        chk("R4 up valid", 32'(eng_up_valid), 32'(|(e & pb[7:5])));
        chk("R4 up data", 32'(eng_up_data), 32'(sel_byte(e, ud)));
        chk("R4 up eof", 32'(eng_up_eof), 32'(|(e & {pb[5], pb[7], pb[6]})));
        chk("R5 up ready", 32'(up_ready), 32'(e & {N{pb[1]}}));
      end
    end

    // R7: downstream frame opened on channel 2 holds across address change
    @(negedge clk);
    idle_inputs();
    eng_addr = 4'd2; dn_ready = 3'b111;
    eng_dn_valid = 1'b1; eng_dn_sof = 1'b1; eng_dn_data = 8'hA1;
    #2;
    chk("R7 sof beat routed", 32'(dn_valid), 32'(3'b010));
    chk("R2 sof copied", 32'(dn_sof), 32'(3'b111));
    @(negedge clk);
    eng_addr = 4'd3; eng_dn_sof = 1'b0; eng_dn_valid = 1'b0;
    #2;
    chk("R7 held during frame", 32'(ch_en), 32'(3'b010));
    chk("R6 stall drops valid", 32'(dn_valid), 32'(0));
    chk("R3 ready during stall", 32'(eng_dn_ready), 32'(1));
    @(negedge clk);
    eng_dn_valid = 1'b1; eng_dn_data = 8'h5C;
    #2;
    chk("R6 resume valid", 32'(dn_valid), 32'(3'b010));
    chk("R6 resume byte", 32'(dn_data[DW +: DW]), 32'(8'h5C));
    @(negedge clk);
    eng_dn_eof = 1'b1; eng_dn_data = 8'h77;
    #2;
    chk("R7 held on eof beat", 32'(ch_en), 32'(3'b010));
    @(negedge clk);
    eng_dn_valid = 1'b0; eng_dn_eof = 1'b0;
    #2;
    chk("R8 release after eof", 32'(ch_en), 32'(3'b100));

    // R7: a frame-start that is not accepted opens nothing
    @(negedge clk);
    eng_addr = 4'd1; dn_ready = 3'b110;
    eng_dn_valid = 1'b1; eng_dn_sof = 1'b1;
    #2;
    chk("R3 unready channel", 32'(eng_dn_ready), 32'(0));
    @(negedge clk);
    eng_addr = 4'd2; eng_dn_valid = 1'b0; eng_dn_sof = 1'b0; dn_ready = 3'b111;
    #2;
    chk("R7 rejected sof no hold", 32'(ch_en), 32'(3'b010));

    // R8: single-beat frame does not hold the selection
    @(negedge clk);
    eng_addr = 4'd1; eng_dn_valid = 1'b1; eng_dn_sof = 1'b1; eng_dn_eof = 1'b1;
    @(negedge clk);
    eng_addr = 4'd3; eng_dn_valid = 1'b0; eng_dn_sof = 1'b0; eng_dn_eof = 1'b0;
    #2;
    chk("R8 one-beat frame", 32'(ch_en), 32'(3'b100));

    // R7: upstream frame opened on channel 1 holds across address change
    @(negedge clk);
    idle_inputs();
    eng_addr = 4'd1; eng_up_ready = 1'b1; up_valid = 3'b111;
    up_data = {8'h33, 8'h22, 8'h11}; up_sof = 3'b001;
    #2;
    chk("R4 up sof", 32'(eng_up_sof), 32'(1));
    @(negedge clk);
    eng_addr = 4'd2; up_sof = 3'b000;
    #2;
    chk("R7 upstream hold", 32'(ch_en), 32'(3'b001));
    chk("R7 upstream byte", 32'(eng_up_data), 32'(8'h11));
    chk("R5 upstream ready held", 32'(up_ready), 32'(3'b001));
    @(negedge clk);
    up_eof = 3'b001;
    @(negedge clk);
    up_eof = 3'b000;
    #2;
    chk("R8 upstream release", 32'(ch_en), 32'(3'b010));
    chk("R4 new channel byte", 32'(eng_up_data), 32'(8'h22));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule